// File: doc/BRIEF.md
# Write Data Interleave Order Checker

This block is a passive monitor for the write side of an AXI3-style interface. It watches the address and data handshakes and raises an error when the data stream breaks the ordering rules. It only observes and drives no channel signal. It records every accepted address (its ID and burst length) in a table kept in arrival order. It then matches each accepted data beat to an entry by ID and counts the beats of that entry.

The rule it enforces applies to first beats only. The first beat of each burst must arrive in the same order as the addresses were accepted. Once a burst has started, its later beats may mix freely with the beats of other started bursts. A build-time switch selects a strict mode for slaves that cannot take interleaved data. In strict mode each burst must run to completion before any other burst's beat appears.

Each error is reported as a one-cycle pulse with a code on the cycle after the offending handshake. A sticky flag records that any error has occurred.

Top module: `wr_order_mon`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears err_pulse, err_code and err_sticky to 0 and empties the outstanding table, so a data beat accepted after reset is reported as unknown (code 2).
- R2: If an accepted data beat is the first beat of its transaction and that transaction is not the oldest outstanding transaction without data, the block reports code 1 (order). The beat is still counted against its transaction.
- R3: With INTERLEAVE=1, later beats of transactions that have already started may arrive in any mix across IDs without raising an error.
- R4: An accepted data beat whose ID matches no outstanding transaction is reported as code 2 (unknown) and changes no table state.
- R5: A transaction with length field L expects L+1 beats. The last flag on any other beat, or a missing last flag on beat L+1, is reported as code 3 (length). The entry retires on whichever comes first: the beat carrying last, or beat L+1.
- R6: With INTERLEAVE=0, an accepted beat is reported as code 4 (interleave) if any other transaction has started and not yet retired.
- R7: An address handshake while DEPTH transactions are outstanding is reported as code 5 (overflow), and that address is not recorded.
- R8: Only cycles in which valid and ready are both high count as handshakes. Cycles without any handshake never produce an error pulse.
- R9: When an address handshake and a data handshake occur in the same cycle, the address is recorded first, so that beat may be the first beat of that new transaction.
- R10: err_pulse is high for exactly one cycle per offending handshake cycle, one cycle after it, and err_code is 0 whenever err_pulse is low. If several errors occur in one cycle, the code reported follows the priority unknown, then order, then interleave, then length, then overflow.
- R11: err_sticky goes high together with the first error pulse and stays high until reset.
- R12: Retiring an entry frees its slot for a new address. The next transaction without data, in address order, becomes the only one allowed a first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_id | input | ID_W | Transaction ID on the address channel |
| aw_len | input | LEN_W | Burst length field (beats minus one) |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_id | input | ID_W | Transaction ID on the data channel |
| w_last | input | 1 | Final beat marker |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 3 | 0 none, 1 order, 2 unknown, 3 length, 4 interleave, 5 overflow |
| err_sticky | output | 1 | Set by any error, cleared by reset |

## Verification
The bench builds two instances that share one stimulus stream. Both use ID_W=4, LEN_W=4 and DEPTH=4; one has INTERLEAVE=1 and the other INTERLEAVE=0. A four-entry table lets overflow, slot reuse after retirement, and the overflow-versus-unknown priority all be reached within a few cycles. Because the strict instance sees the same interleaved traffic as the permissive one, each stream checks both modes against each other cycle by cycle. The legal interleave scenario must be clean in one mode and flagged in the other.

// File: rtl/wom_pkg.sv
package wom_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE    = 3'd0,
        ERR_ORDER   = 3'd1,
        ERR_UNKNOWN = 3'd2,
        ERR_LENGTH  = 3'd3,
        ERR_ILV     = 3'd4,
        ERR_OVFL    = 3'd5
    } err_code_e;

endpackage

// File: rtl/wom_table.sv
module wom_table #(
    parameter int ID_W  = 4,
    parameter int LEN_W = 4,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             aw_fire,
    input  logic [ID_W-1:0]                  aw_id,
    input  logic [LEN_W-1:0]                 aw_len,
    input  logic                             upd_en,
    input  logic [IDX_W-1:0]                 upd_idx,
    input  logic                             upd_retire,
    output logic [DEPTH-1:0]                 v_vld,
    output logic [DEPTH-1:0][ID_W-1:0]       v_id,
    output logic [DEPTH-1:0][LEN_W-1:0]      v_len,
    output logic [DEPTH-1:0][CNT_W-1:0]      v_cnt,
    output logic [DEPTH-1:0]                 v_start,
    output logic                             ovfl
);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][ID_W-1:0]  id;
        logic [DEPTH-1:0][LEN_W-1:0] len;
        logic [DEPTH-1:0][CNT_W-1:0] cnt;
        logic [DEPTH-1:0]            start;
    } tbl_t;

    tbl_t tbl_q, tbl_d, view, shf;
    logic placed;

    // Address first: append the incoming entry, then apply the beat update.
    always_comb begin
        view   = tbl_q;
        ovfl   = 1'b0;
        placed = 1'b0;
        if (aw_fire) begin
            if (tbl_q.vld[DEPTH-1]) begin
                ovfl = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!placed && !view.vld[i]) begin
                        placed        = 1'b1;
                        view.vld[i]   = 1'b1;
                        view.id[i]    = aw_id;
                        view.len[i]   = aw_len;
                        view.cnt[i]   = '0;
                        view.start[i] = 1'b0;
                    end
                end
            end
        end

        tbl_d = view;
        if (upd_en) begin
            tbl_d.start[upd_idx] = 1'b1;
            tbl_d.cnt[upd_idx]   = tbl_d.cnt[upd_idx] + CNT_W'(1);
            if (upd_retire) begin
                shf = tbl_d;
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (i >= int'(upd_idx)) begin
                        tbl_d.vld[i]   = shf.vld[i+1];
                        tbl_d.id[i]    = shf.id[i+1];
                        tbl_d.len[i]   = shf.len[i+1];
                        tbl_d.cnt[i]   = shf.cnt[i+1];
                        tbl_d.start[i] = shf.start[i+1];
                    end
                end
                tbl_d.vld[DEPTH-1]   = 1'b0;
                tbl_d.id[DEPTH-1]    = '0;
                tbl_d.len[DEPTH-1]   = '0;
                tbl_d.cnt[DEPTH-1]   = '0;
                tbl_d.start[DEPTH-1] = 1'b0;
            end else begin
                shf = tbl_d;
            end
        end else begin
            shf = tbl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign v_vld   = view.vld;
    assign v_id    = view.id;
    assign v_len   = view.len;
    assign v_cnt   = view.cnt;
    assign v_start = view.start;

    // R12: live entries always form a packed prefix in arrival order
    a_r12_packed_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        ((tbl_q.vld + DEPTH'(1)) & tbl_q.vld) == '0);

    // R7: a refused address never frees the last slot on its own
    a_r7_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_fire && tbl_q.vld[DEPTH-1] && !(upd_en && upd_retire)) |=> tbl_q.vld[DEPTH-1]);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cnt_chk
        // R5: an entry never holds more beats than its length field
        a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_q.vld[g] |-> (tbl_q.cnt[g] <= CNT_W'(tbl_q.len[g])));
    end

endmodule

// File: rtl/wom_eval.sv
module wom_eval
    import wom_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int LEN_W      = 4,
    parameter int DEPTH      = 8,
    parameter bit INTERLEAVE = 1'b1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic [DEPTH-1:0]            v_vld,
    input  logic [DEPTH-1:0][ID_W-1:0]  v_id,
    input  logic [DEPTH-1:0][LEN_W-1:0] v_len,
    input  logic [DEPTH-1:0][CNT_W-1:0] v_cnt,
    input  logic [DEPTH-1:0]            v_start,
    input  logic                        w_fire,
    input  logic [ID_W-1:0]             w_id,
    input  logic                        w_last,
    output logic                        upd_en,
    output logic [IDX_W-1:0]            upd_idx,
    output logic                        upd_retire,
    output err_code_e                   code
);

    logic             s_hit, u_hit, f_hit, hit;
    logic [IDX_W-1:0] s_idx, u_idx, f_idx;
    logic [CNT_W-1:0] beat_no, beat_end;
    logic             at_end;
    int               n_start;

    always_comb begin
        s_hit   = 1'b0;
        u_hit   = 1'b0;
        f_hit   = 1'b0;
        s_idx   = '0;
        u_idx   = '0;
        f_idx   = '0;
        n_start = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (v_vld[i] && v_start[i]) n_start = n_start + 1;
            if (!s_hit && v_vld[i] && v_start[i] && v_id[i] == w_id) begin
                s_hit = 1'b1;
                s_idx = IDX_W'(i);
            end
            if (!u_hit && v_vld[i] && !v_start[i] && v_id[i] == w_id) begin
                u_hit = 1'b1;
                u_idx = IDX_W'(i);
            end
            if (!f_hit && v_vld[i] && !v_start[i]) begin
                f_hit = 1'b1;
                f_idx = IDX_W'(i);
            end
        end

        hit      = s_hit || u_hit;
        upd_idx  = s_hit ? s_idx : u_idx;
        beat_no  = v_cnt[upd_idx] + CNT_W'(1);
        beat_end = CNT_W'(v_len[upd_idx]) + CNT_W'(1);
        at_end   = (beat_no == beat_end);

        upd_en     = w_fire && hit;
        upd_retire = w_last || at_end;

        if (!w_fire)
            code = ERR_NONE;
        else if (!hit)
            code = ERR_UNKNOWN;
        else if (!s_hit && (u_idx != f_idx))
            code = ERR_ORDER;
        else if (!INTERLEAVE && (n_start - (s_hit ? 1 : 0)) != 0)
            code = ERR_ILV;
        else if (w_last != at_end)
            code = ERR_LENGTH;
        else
            code = ERR_NONE;
    end

endmodule

// File: rtl/wom_err.sv
module wom_err
    import wom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  err_code_e         beat_code,
    input  logic              ovfl,
    output logic              err_pulse,
    output logic [CODE_W-1:0] err_code,
    output logic              err_sticky
);

    typedef struct packed {
        logic      pulse;
        err_code_e code;
        logic      sticky;
    } rep_t;

    rep_t rep_q, rep_d;

    always_comb begin
        rep_d = rep_q;
        if (beat_code != ERR_NONE) rep_d.code = beat_code;
        else if (ovfl)             rep_d.code = ERR_OVFL;
        else                       rep_d.code = ERR_NONE;
        rep_d.pulse  = (rep_d.code != ERR_NONE);
        rep_d.sticky = rep_q.sticky || rep_d.pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '{pulse: 1'b0, code: ERR_NONE, sticky: 1'b0};
        else        rep_q <= rep_d;
    end

    assign err_pulse  = rep_q.pulse;
    assign err_code   = rep_q.code;
    assign err_sticky = rep_q.sticky;

    // R11: the sticky flag never drops without reset
    a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R11: every pulse is already reflected in the sticky flag
    a_r11_pulse_marks_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);

endmodule

// File: rtl/wr_order_mon.sv
module wr_order_mon
    import wom_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int LEN_W      = 4,
    parameter int DEPTH      = 8,
    parameter bit INTERLEAVE = 1'b1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              w_valid,
    input  logic              w_ready,
    input  logic [ID_W-1:0]   w_id,
    input  logic              w_last,
    output logic              err_pulse,
    output logic [CODE_W-1:0] err_code,
    output logic              err_sticky
);

    logic                        aw_fire, w_fire;
    logic [DEPTH-1:0]            v_vld, v_start;
    logic [DEPTH-1:0][ID_W-1:0]  v_id;
    logic [DEPTH-1:0][LEN_W-1:0] v_len;
    logic [DEPTH-1:0][CNT_W-1:0] v_cnt;
    logic                        upd_en, upd_retire, ovfl;
    logic [IDX_W-1:0]            upd_idx;
    err_code_e                   beat_code;

    assign aw_fire = aw_valid && aw_ready;
    assign w_fire  = w_valid && w_ready;

    wom_table #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) table_i (
        .clk(clk), .rst_n(rst_n),
        .aw_fire(aw_fire), .aw_id(aw_id), .aw_len(aw_len),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_retire(upd_retire),
        .v_vld(v_vld), .v_id(v_id), .v_len(v_len), .v_cnt(v_cnt),
        .v_start(v_start), .ovfl(ovfl)
    );

    wom_eval #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .INTERLEAVE(INTERLEAVE)) eval_i (
        .v_vld(v_vld), .v_id(v_id), .v_len(v_len), .v_cnt(v_cnt), .v_start(v_start),
        .w_fire(w_fire), .w_id(w_id), .w_last(w_last),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_retire(upd_retire),
        .code(beat_code)
    );

    wom_err err_i (
        .clk(clk), .rst_n(rst_n),
        .beat_code(beat_code), .ovfl(ovfl),
        .err_pulse(err_pulse), .err_code(err_code), .err_sticky(err_sticky)
    );

    // R8: a cycle with no handshake on either channel is followed by no pulse
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!aw_fire && !w_fire) |=> !err_pulse);

endmodule

// File: tb/wr_order_mon_tb.sv
module wr_order_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;
    localparam int NV         = 46;

    typedef struct packed {
        logic       awv;
        logic       awr;
        logic [3:0] aid;
        logic [3:0] alen;
        logic       wv;
        logic       wr;
        logic [3:0] wid;
        logic       wl;
        logic [2:0] e_il;
        logic [2:0] e_ni;
    } vec_t;

    // Rows: address (valid, ready, id, len), data (valid, ready, id, last),
    // expected code for the interleaving and the strict instance.
    localparam vec_t VEC [0:NV-1] = '{
        // R3/R6: legal interleave, later beats of ID 1 overtake ID 0
        '{1'b1,1'b1,4'd0,4'd3, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd1,4'd3, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd0,3'd4},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd0,3'd4},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd0,3'd4},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b1, 3'd0,3'd4},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b1, 3'd0,3'd0},
        // R8: valid without ready is no handshake; R4 then unknown ID
        '{1'b1,1'b0,4'd2,4'd0, 1'b1,1'b0,4'd5,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd2,1'b1, 3'd2,3'd2},
        // R2: whole burst of ID 1 before ID 0
        '{1'b1,1'b1,4'd0,4'd3, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd1,4'd3, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd1,3'd1},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd0,1'b1, 3'd0,3'd0},
        // R5: early last, missing last; R9: same-cycle address and beat
        '{1'b1,1'b1,4'd3,4'd1, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd3,1'b1, 3'd3,3'd3},
        '{1'b1,1'b1,4'd4,4'd0, 1'b1,1'b1,4'd4,1'b0, 3'd3,3'd3},
        '{1'b1,1'b1,4'd5,4'd0, 1'b1,1'b1,4'd5,1'b1, 3'd0,3'd0},
        // R7: fill four slots, overflow, refused ID unknown; R12 reuse
        '{1'b1,1'b1,4'd6,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd7,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd8,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd9,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd10,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd5,3'd5},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd10,1'b1, 3'd2,3'd2},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd6,1'b1, 3'd0,3'd0},
        '{1'b1,1'b1,4'd11,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd7,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd8,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd9,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd11,1'b1, 3'd0,3'd0},
        // R10: overflow and unknown in one cycle, unknown wins
        '{1'b1,1'b1,4'd1,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd2,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd3,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd4,4'd0, 1'b0,1'b0,4'd0,1'b0, 3'd0,3'd0},
        '{1'b1,1'b1,4'd5,4'd0, 1'b1,1'b1,4'd15,1'b1, 3'd2,3'd2},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd1,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd2,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd3,1'b1, 3'd0,3'd0},
        '{1'b0,1'b0,4'd0,4'd0, 1'b1,1'b1,4'd4,1'b1, 3'd0,3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aw_valid = 1'b0, aw_ready = 1'b0, w_valid = 1'b0, w_ready = 1'b0, w_last = 1'b0;
    logic [3:0] aw_id = '0, aw_len = '0, w_id = '0;
    logic       il_pulse, il_sticky, ni_pulse, ni_sticky;
    logic [2:0] il_code, ni_code;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_order_mon #(.ID_W(4), .LEN_W(4), .DEPTH(4), .INTERLEAVE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
        .err_pulse(il_pulse), .err_code(il_code), .err_sticky(il_sticky)
    );

    wr_order_mon #(.ID_W(4), .LEN_W(4), .DEPTH(4), .INTERLEAVE(1'b0)) dut_ni_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
        .err_pulse(ni_pulse), .err_code(ni_code), .err_sticky(ni_sticky)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        aw_valid = 1'b0; aw_ready = 1'b0; aw_id = '0; aw_len = '0;
        w_valid = 1'b0; w_ready = 1'b0; w_id = '0; w_last = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) step();
        // R1: reset state
        check("R1 pulse after reset", il_pulse, 0);
        check("R1 code after reset", il_code, 0);
        check("R1 sticky after reset", il_sticky, 0);
        check("R1 strict sticky after reset", ni_sticky, 0);
        rst_n = 1'b1;
        step();

        for (int v = 0; v < NV; v++) begin
            aw_valid = VEC[v].awv; aw_ready = VEC[v].awr;
            aw_id    = VEC[v].aid; aw_len   = VEC[v].alen;
            w_valid  = VEC[v].wv;  w_ready  = VEC[v].wr;
            w_id     = VEC[v].wid; w_last   = VEC[v].wl;
            step();
            check($sformatf("R10 row %0d interleave code (R2-R9)", v), il_code, VEC[v].e_il);
            check($sformatf("R10 row %0d interleave pulse", v), il_pulse, (VEC[v].e_il != 0) ? 1 : 0);
            check($sformatf("R6 row %0d strict code", v), ni_code, VEC[v].e_ni);
            check($sformatf("R10 row %0d strict pulse", v), ni_pulse, (VEC[v].e_ni != 0) ? 1 : 0);
        end

        // R11: sticky holds through quiet cycles
        idle_inputs();
        for (int k = 0; k < 3; k++) begin
            step();
            check("R11 sticky holds", il_sticky, 1);
            check("R8 quiet cycle no pulse", il_pulse, 0);
        end

        // R1/R11: reset clears sticky and table
        rst_n = 1'b0;
        step();
        check("R1 sticky cleared by reset", il_sticky, 0);
        check("R1 strict sticky cleared by reset", ni_sticky, 0);
        check("R1 code cleared by reset", il_code, 0);
        rst_n = 1'b1;
        step();
        w_valid = 1'b1; w_ready = 1'b1; w_id = 4'd0; w_last = 1'b1;
        step();
        check("R1 table empty after reset", il_code, 2);
        check("R11 sticky set by first pulse", il_sticky, 1);
        idle_inputs();
        step();
        check("R10 pulse lasts one cycle", il_pulse, 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule